// File: doc/BRIEF.md
# MESI Line-State Controller for a Snooping Cache

This block tracks the coherence state of every line in a small direct-mapped cache. The cache belongs to one processor on a shared snooping bus that uses write-invalidate coherence. Each line holds a tag and a two-bit state: Modified, Exclusive, Shared or Invalid. The local processor presents read and write requests by line address. The block reports hit or miss. When the request needs the bus, the block raises a request naming a bus command and a line address, and holds it until the arbiter grants it. A dirty victim is written back before the new line is fetched.

The snoop side observes one transaction per cycle from the other caches and updates the matching line. One cycle later it reports two things: whether this cache holds a copy (the shared signal), and whether it must provide dirty data (the supply signal). The data array, the memory, and bus arbitration live outside the block. Data movement appears only as the grant strobe and the supply signal. A snooped transaction takes priority over local activity in the same cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `lcl_ready` is high, and `bus_req`, `lcl_resp_valid`, `snp_shared_out` and `snp_supply_out` are low. Bus and snoop command codes are: 0 read, 1 read-with-intent-to-modify, 2 invalidate, 3 write-back. An address is `{tag, index}`, with the index in the low `IDX_W` bits.
- R2: A local read miss issues a bus read of the requested address. If `bus_shared_in` is low at the grant, the line is installed Exclusive, and the response reports a miss.
- R3: A local read miss granted with `bus_shared_in` high installs the line Shared.
- R4: A local write hit on a Shared line issues an invalidate for that address. The line becomes Modified, and the response reports a hit.
- R5: A local write hit on an Exclusive line makes it Modified without any bus request.
- R6: A local write hit on a Modified line leaves it Modified without any bus request. A local read hit never uses the bus.
- R7: A local write miss issues a read-with-intent-to-modify and installs the line Modified. The response reports a miss.
- R8: A snooped read that hits a Modified line raises both `snp_shared_out` and `snp_supply_out` in the next cycle, and the line becomes Shared.
- R9: A snooped read that hits an Exclusive or Shared line raises only `snp_shared_out`, and the line becomes Shared.
- R10: A snooped read-with-intent-to-modify or invalidate that hits a valid line makes it Invalid. `snp_supply_out` rises only if the line was Modified, and `snp_shared_out` stays low.
- R11: A miss whose indexed line is Modified under another tag first issues a write-back of the victim's address. It then issues the fetch for the requested address.
- R12: A snooped write-back, or a snoop whose tag does not match, changes no line and raises neither output.
- R13: `lcl_ready` is low in a cycle with `snp_valid` high. A bus request stays high until it is granted in a cycle without a snoop. While the request waits, its command follows the current line state: an upgrade whose line a snoop has invalidated becomes a read-with-intent-to-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_req_valid | input | 1 | Local request present |
| lcl_req_write | input | 1 | Local request is a write |
| lcl_req_addr | input | ADDR_W | Local line address |
| lcl_ready | output | 1 | Local request accepted this cycle if valid |
| lcl_resp_valid | output | 1 | Local request completed (one-cycle pulse) |
| lcl_resp_hit | output | 1 | Completed request hit at acceptance |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | Requested bus command code |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Requested transaction takes place this cycle |
| bus_shared_in | input | 1 | Another cache reports a copy during our read |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared_out | output | 1 | This cache held the snooped line for a read |
| snp_supply_out | output | 1 | This cache must supply or write back dirty data |

## Verification
One line is driven around the full state cycle: Exclusive, then Modified, then Shared through a snoop, then Modified again through an upgrade, then Invalid through a snoop. After each step, the presence or absence of a bus request tells the four states apart at the ports. The same sequences are repeated with `bus_shared_in` high and low, so that a Shared install can be told from an Exclusive one. Snoops on mismatching tags and write-back snoops check that other lines stay untouched. A victim eviction checks the order of write-back and fetch. A grant held back while a snoop invalidates the waiting line shows that the command follows the current line state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BC_RD  = 2'd0,
        BC_RDX = 2'd1,
        BC_INV = 2'd2,
        BC_WB  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_ACT  = 1'b1
    } fsm_e;

    // state a line takes after another cache's transaction hits it
    function automatic line_st_e snoop_next(line_st_e st, bus_cmd_e cmd);
        line_st_e nx;
        nx = st;
        case (cmd)
            BC_RD:          nx = (st == LN_I) ? LN_I : LN_S;
            BC_RDX, BC_INV: nx = LN_I;
            default:        nx = st;
        endcase
        return nx;
    endfunction

    // dirty data must leave this cache
    function automatic logic snoop_supply(line_st_e st, bus_cmd_e cmd);
        return (st == LN_M) && (cmd != BC_WB);
    endfunction

endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd0_idx_i,
    output logic [TAG_W-1:0] rd0_tag_o,
    output line_st_e         rd0_st_o,
    input  logic [IDX_W-1:0] rd1_idx_i,
    output logic [TAG_W-1:0] rd1_tag_o,
    output line_st_e         rd1_st_o,
    input  logic             wr_en_i,
    input  logic             wr_tag_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  line_st_e         wr_st_i
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_arr [LINES];
    line_st_e         st_arr  [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        line_st_e         st_q;
        logic             sel;
        assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q <= '0;
                st_q  <= LN_I;
            end else if (sel) begin
                st_q <= wr_st_i;
                if (wr_tag_en_i) tag_q <= wr_tag_i;
            end
        end
        assign tag_arr[i] = tag_q;
        assign st_arr[i]  = st_q;
    end

    assign rd0_tag_o = tag_arr[rd0_idx_i];
    assign rd0_st_o  = st_arr[rd0_idx_i];
    assign rd1_tag_o = tag_arr[rd1_idx_i];
    assign rd1_st_o  = st_arr[rd1_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid_i,
    input  bus_cmd_e         snp_cmd_i,
    input  logic [TAG_W-1:0] snp_tag_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  line_st_e         line_st_i,
    output logic             wr_en_o,
    output line_st_e         wr_st_o,
    output logic             shared_o,
    output logic             supply_o
);
    logic snp_hit;

    assign snp_hit = snp_valid_i && (line_st_i != LN_I) && (line_tag_i == snp_tag_i);
    assign wr_st_o = snoop_next(line_st_i, snp_cmd_i);
    assign wr_en_o = snp_hit && (wr_st_o != line_st_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            shared_o <= 1'b0;
            supply_o <= 1'b0;
        end else begin
            shared_o <= snp_hit && (snp_cmd_i == BC_RD);
            supply_o <= snp_hit && snoop_supply(line_st_i, snp_cmd_i);
        end
    end

    // R8
    supply_src_chk: assert property (@(posedge clk) disable iff (rst)
        supply_o |-> $past(snp_valid_i && snp_cmd_i != BC_WB));

    // R9
    shared_src_chk: assert property (@(posedge clk) disable iff (rst)
        shared_o |-> $past(snp_valid_i && snp_cmd_i == BC_RD));
endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
    import mesi_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid_i,
    input  logic                   req_write_i,
    input  logic [TAG_W+IDX_W-1:0] req_addr_i,
    input  logic                   snp_busy_i,
    output logic [IDX_W-1:0]       look_idx_o,
    input  logic [TAG_W-1:0]       line_tag_i,
    input  line_st_e               line_st_i,
    output logic                   lcl_ready_o,
    output logic                   bus_req_o,
    output bus_cmd_e               bus_cmd_o,
    output logic [TAG_W+IDX_W-1:0] bus_addr_o,
    input  logic                   bus_gnt_i,
    input  logic                   bus_shared_i,
    output logic                   wr_en_o,
    output logic                   wr_tag_en_o,
    output logic [TAG_W-1:0]       wr_tag_o,
    output line_st_e               wr_st_o,
    output logic                   resp_valid_o,
    output logic                   resp_hit_o
);
    fsm_e             fsm_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             wr_q, hit_q;
    logic [TAG_W-1:0] cur_tag;
    logic             act, go, lk_hit, need_bus, done;

    assign act         = (fsm_q == FS_ACT);
    assign go          = act && !snp_busy_i;
    assign cur_tag     = act ? tag_q : req_addr_i[TAG_W+IDX_W-1:IDX_W];
    assign look_idx_o  = act ? idx_q : req_addr_i[IDX_W-1:0];
    assign lk_hit      = (line_st_i != LN_I) && (line_tag_i == cur_tag);
    assign lcl_ready_o = !act && !snp_busy_i;
    assign bus_req_o   = act && need_bus;
    assign wr_tag_o    = tag_q;

    // bus command follows the line state seen now
    always_comb begin
        need_bus   = 1'b0;
        bus_cmd_o  = BC_RD;
        bus_addr_o = {cur_tag, look_idx_o};
        if (lk_hit) begin
            if (wr_q && line_st_i == LN_S) begin
                need_bus  = 1'b1;
                bus_cmd_o = BC_INV;
            end
        end else if (line_st_i == LN_M) begin
            need_bus   = 1'b1;
            bus_cmd_o  = BC_WB;
            bus_addr_o = {line_tag_i, look_idx_o};
        end else begin
            need_bus  = 1'b1;
            bus_cmd_o = wr_q ? BC_RDX : BC_RD;
        end
    end

    always_comb begin
        wr_en_o     = 1'b0;
        wr_tag_en_o = 1'b0;
        wr_st_o     = LN_I;
        done        = 1'b0;
        if (go) begin
            if (!need_bus) begin
                done = 1'b1;
                if (wr_q) begin
                    wr_en_o = 1'b1;
                    wr_st_o = LN_M;
                end
            end else if (bus_gnt_i) begin
                wr_en_o = 1'b1;
                case (bus_cmd_o)
                    BC_WB:  wr_st_o = LN_I;
                    BC_RD: begin
                        wr_tag_en_o = 1'b1;
                        wr_st_o     = bus_shared_i ? LN_S : LN_E;
                        done        = 1'b1;
                    end
                    BC_RDX: begin
                        wr_tag_en_o = 1'b1;
                        wr_st_o     = LN_M;
                        done        = 1'b1;
                    end
                    default: begin
                        wr_st_o = LN_M;
                        done    = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q        <= FS_IDLE;
            idx_q        <= '0;
            tag_q        <= '0;
            wr_q         <= 1'b0;
            hit_q        <= 1'b0;
            resp_valid_o <= 1'b0;
            resp_hit_o   <= 1'b0;
        end else begin
            resp_valid_o <= 1'b0;
            if (!act) begin
                if (req_valid_i && lcl_ready_o) begin
                    idx_q <= req_addr_i[IDX_W-1:0];
                    tag_q <= req_addr_i[TAG_W+IDX_W-1:IDX_W];
                    wr_q  <= req_write_i;
                    hit_q <= lk_hit;
                    fsm_q <= FS_ACT;
                end
            end else if (done) begin
                fsm_q        <= FS_IDLE;
                resp_valid_o <= 1'b1;
                resp_hit_o   <= hit_q;
            end
        end
    end

    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req_o && !(bus_gnt_i && !snp_busy_i)) |=> bus_req_o);

    // R13
    resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid_o |-> (lcl_ready_o || snp_busy_i));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lcl_req_valid,
    input  logic              lcl_req_write,
    input  logic [ADDR_W-1:0] lcl_req_addr,
    output logic              lcl_ready,
    output logic              lcl_resp_valid,
    output logic              lcl_resp_hit,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared_out,
    output logic              snp_supply_out
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag, sp_tag, l_wr_tag;
    line_st_e         lk_st, sp_st, l_wr_st, s_wr_st, wr_st;
    logic             l_wr_en, l_wr_tag_en, s_wr_en;
    logic             wr_en, wr_tag_en;
    logic [IDX_W-1:0] wr_idx;
    bus_cmd_e         l_cmd;

    assign bus_cmd   = l_cmd;
    assign wr_en     = snp_valid ? s_wr_en : l_wr_en;
    assign wr_tag_en = !snp_valid && l_wr_tag_en;
    assign wr_idx    = snp_valid ? snp_addr[IDX_W-1:0] : lk_idx;
    assign wr_st     = snp_valid ? s_wr_st : l_wr_st;

    mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst(rst),
        .rd0_idx_i(lk_idx), .rd0_tag_o(lk_tag), .rd0_st_o(lk_st),
        .rd1_idx_i(snp_addr[IDX_W-1:0]), .rd1_tag_o(sp_tag), .rd1_st_o(sp_st),
        .wr_en_i(wr_en), .wr_tag_en_i(wr_tag_en), .wr_idx_i(wr_idx),
        .wr_tag_i(l_wr_tag), .wr_st_i(wr_st)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .clk(clk), .rst(rst),
        .snp_valid_i(snp_valid), .snp_cmd_i(bus_cmd_e'(snp_cmd)),
        .snp_tag_i(snp_addr[ADDR_W-1:IDX_W]),
        .line_tag_i(sp_tag), .line_st_i(sp_st),
        .wr_en_o(s_wr_en), .wr_st_o(s_wr_st),
        .shared_o(snp_shared_out), .supply_o(snp_supply_out)
    );

    mesi_local_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_local (
        .clk(clk), .rst(rst),
        .req_valid_i(lcl_req_valid), .req_write_i(lcl_req_write), .req_addr_i(lcl_req_addr),
        .snp_busy_i(snp_valid),
        .look_idx_o(lk_idx), .line_tag_i(lk_tag), .line_st_i(lk_st),
        .lcl_ready_o(lcl_ready),
        .bus_req_o(bus_req), .bus_cmd_o(l_cmd), .bus_addr_o(bus_addr),
        .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared_in),
        .wr_en_o(l_wr_en), .wr_tag_en_o(l_wr_tag_en), .wr_tag_o(l_wr_tag), .wr_st_o(l_wr_st),
        .resp_valid_o(lcl_resp_valid), .resp_hit_o(lcl_resp_hit)
    );

    // R13
    wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s_wr_en && snp_valid, l_wr_en}));

    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(lcl_resp_valid || snp_shared_out || snp_supply_out));
endmodule

// File: tb/mesi_line_ctrl_bench.sv
module mesi_line_ctrl_bench;
    localparam int ADDR_W = 12;
    localparam int IDX_W  = 3;
    localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_INV = 2'd2, C_WB = 2'd3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lcl_req_valid = 1'b0, lcl_req_write = 1'b0;
    logic [ADDR_W-1:0] lcl_req_addr = '0;
    logic lcl_ready, lcl_resp_valid, lcl_resp_hit;
    logic bus_req;
    logic [1:0] bus_cmd;
    logic [ADDR_W-1:0] bus_addr;
    logic bus_gnt = 1'b0, bus_shared_in = 1'b0;
    logic snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_shared_out, snp_supply_out;

    int n_chk = 0, n_fail = 0;
    logic hold_gnt = 1'b0, shared_val = 1'b0;
    logic [ADDR_W+1:0] exp_bus [$];
    logic              exp_resp [$];

    always #2 clk = ~clk;

    mesi_line_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_mesi_line_ctrl (
        .clk(clk), .rst(rst),
        .lcl_req_valid(lcl_req_valid), .lcl_req_write(lcl_req_write), .lcl_req_addr(lcl_req_addr),
        .lcl_ready(lcl_ready), .lcl_resp_valid(lcl_resp_valid), .lcl_resp_hit(lcl_resp_hit),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared_out(snp_shared_out), .snp_supply_out(snp_supply_out)
    );

    function automatic logic [ADDR_W-1:0] mk(int tag, int idx);
        return ADDR_W'((tag << IDX_W) | idx);
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_bus(input logic [1:0] cmd, input logic [ADDR_W-1:0] a);
        exp_bus.push_back({cmd, a});
    endtask

    // responder: grants each request and scores it against the expected queue
    always @(negedge clk) begin
        if (bus_gnt) bus_gnt = 1'b0;
        else if (bus_req && !hold_gnt && !snp_valid) begin
            if (exp_bus.size() == 0) begin
                check(1'b0, "R6", "unexpected bus request", {bus_cmd, bus_addr}, 0);
            end else begin
                automatic logic [ADDR_W+1:0] e = exp_bus.pop_front();
                check({bus_cmd, bus_addr} == e, "R2", "bus cmd/addr", {bus_cmd, bus_addr}, e);
            end
            bus_shared_in = shared_val;
            bus_gnt = 1'b1;
        end
    end

    // monitor: scores local responses
    always @(negedge clk) begin
        if (lcl_resp_valid) begin
            if (exp_resp.size() == 0) check(1'b0, "R1", "unexpected response", 1, 0);
            else begin
                automatic logic e = exp_resp.pop_front();
                check(lcl_resp_hit == e, "R2", "response hit", lcl_resp_hit, e);
            end
        end
    end

    task automatic wait_done(input string req);
        for (int i = 0; i < 60 && exp_resp.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        check(exp_resp.size() == 0, req, "response outstanding", exp_resp.size(), 0);
        check(exp_bus.size() == 0, req, "bus transaction outstanding", exp_bus.size(), 0);
        exp_resp.delete();
        exp_bus.delete();
    endtask

    task automatic issue(input logic [ADDR_W-1:0] a, input logic wr);
        while (!lcl_ready) @(negedge clk);
        lcl_req_valid = 1'b1;
        lcl_req_write = wr;
        lcl_req_addr  = a;
        @(negedge clk);
        lcl_req_valid = 1'b0;
    endtask

    task automatic access(input logic [ADDR_W-1:0] a, input logic wr, input logic hit,
                          input logic sh, input string req);
        shared_val = sh;
        exp_resp.push_back(hit);
        issue(a, wr);
        wait_done(req);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [ADDR_W-1:0] a,
                         input logic e_sh, input logic e_sup, input string req);
        snp_valid = 1'b1;
        snp_cmd   = cmd;
        snp_addr  = a;
        @(negedge clk);
        snp_valid = 1'b0;
        check(snp_shared_out == e_sh, req, "snoop shared", snp_shared_out, e_sh);
        check(snp_supply_out == e_sup, req, "snoop supply", snp_supply_out, e_sup);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [ADDR_W-1:0] a, b, c, d, e, f, g;
        a = mk(1, 0); b = mk(2, 1); c = mk(4, 2); d = mk(5, 3);
        e = mk(6, 3); f = mk(7, 4); g = mk(1, 5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(lcl_ready == 1'b1, "R1", "ready after reset", lcl_ready, 1);
        check(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
        check(lcl_resp_valid == 1'b0, "R1", "resp after reset", lcl_resp_valid, 0);
        check({snp_shared_out, snp_supply_out} == 2'b00, "R1", "snoop outs after reset",
              {snp_shared_out, snp_supply_out}, 0);
        snoop(C_RD, a, 1'b0, 1'b0, "R1");

        // R2 read miss, no sharer -> Exclusive
        push_bus(C_RD, a);
        access(a, 1'b0, 1'b0, 1'b0, "R2");
        access(a, 1'b0, 1'b1, 1'b0, "R6");      // read hit, no bus
        access(a, 1'b1, 1'b1, 1'b0, "R5");      // E -> M silently
        access(a, 1'b1, 1'b1, 1'b0, "R6");      // M stays M
        snoop(C_RD, a, 1'b1, 1'b1, "R8");       // M -> S with supply
        push_bus(C_INV, a);
        access(a, 1'b1, 1'b1, 1'b0, "R4");      // S upgrade
        snoop(C_INV, a, 1'b0, 1'b1, "R10");     // M -> I with write-back
        push_bus(C_RD, a);
        access(a, 1'b0, 1'b0, 1'b1, "R3");      // miss, sharer present -> S
        push_bus(C_INV, a);
        access(a, 1'b1, 1'b1, 1'b0, "R3");      // proves it was S

        // R9 snoop read on Exclusive
        push_bus(C_RD, b);
        access(b, 1'b0, 1'b0, 1'b0, "R9");
        snoop(C_RD, b, 1'b1, 1'b0, "R9");
        push_bus(C_INV, b);
        access(b, 1'b1, 1'b1, 1'b0, "R9");

        // R12 non-matching and write-back snoops leave b Modified
        snoop(C_RD, mk(3, 1), 1'b0, 1'b0, "R12");
        snoop(C_RDX, mk(3, 1), 1'b0, 1'b0, "R12");
        snoop(C_WB, b, 1'b0, 1'b0, "R12");
        access(b, 1'b1, 1'b1, 1'b0, "R12");

        // R7 write miss
        push_bus(C_RDX, c);
        access(c, 1'b1, 1'b0, 1'b0, "R7");
        snoop(C_RDX, c, 1'b0, 1'b1, "R7");
        push_bus(C_RD, c);
        access(c, 1'b0, 1'b0, 1'b0, "R10");
        snoop(C_RDX, c, 1'b0, 1'b0, "R10");     // E -> I, no supply
        push_bus(C_RD, c);
        access(c, 1'b0, 1'b0, 1'b0, "R10");

        // R11 dirty victim
        push_bus(C_RDX, d);
        access(d, 1'b1, 1'b0, 1'b0, "R11");
        push_bus(C_WB, d);
        push_bus(C_RD, e);
        access(e, 1'b0, 1'b0, 1'b0, "R11");

        // R13 ready drops during snoop
        snp_valid = 1'b1; snp_cmd = C_WB; snp_addr = f;
        #1;
        check(lcl_ready == 1'b0, "R13", "ready during snoop", lcl_ready, 0);
        @(negedge clk);
        snp_valid = 1'b0;
        @(negedge clk);

        // R13 request held without grant
        hold_gnt = 1'b1;
        issue(f, 1'b0);
        for (int i = 0; i < 3; i++) begin
            check(bus_req && bus_cmd == C_RD && bus_addr == f, "R13", "held request",
                  {bus_req, bus_cmd, bus_addr}, {1'b1, C_RD, f});
            @(negedge clk);
        end
        push_bus(C_RD, f);
        exp_resp.push_back(1'b0);
        shared_val = 1'b0;
        hold_gnt = 1'b0;
        wait_done("R13");

        // R13 upgrade turns into read-with-intent after snooped invalidate
        push_bus(C_RD, g);
        access(g, 1'b0, 1'b0, 1'b1, "R3");
        hold_gnt = 1'b1;
        issue(g, 1'b1);
        check(bus_req && bus_cmd == C_INV, "R13", "upgrade cmd", {bus_req, bus_cmd}, {1'b1, C_INV});
        snoop(C_INV, g, 1'b0, 1'b0, "R13");
        check(bus_req && bus_cmd == C_RDX && bus_addr == g, "R13", "cmd after invalidate",
              {bus_req, bus_cmd, bus_addr}, {1'b1, C_RDX, g});
        push_bus(C_RDX, g);
        exp_resp.push_back(1'b1);
        hold_gnt = 1'b0;
        wait_done("R13");
        access(g, 1'b1, 1'b1, 1'b0, "R7");      // installed Modified

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule